// File: doc/BRIEF.md
# Idle-timeout SDRAM low-power controller

The block watches the access port of a memory controller and counts consecutive cycles with no access request. When the count reaches the timeout for the selected low-power state, it issues a one-cycle entry command. The state is one of clock stop, self-refresh or power-down. The first access request that arrives while the SDRAM is in that state produces a one-cycle exit command. After an exit from self-refresh or power-down, the block issues a long ZQ calibration command and holds the access port stalled until the calibration window has elapsed. Only then does it grant the access.

Software gives the timeout as a requested cycle count, with one value for high clock frequencies and one for low ones. The block converts the requested count into a log2 code with a fixed width. A code value `c` means an idle window of 2^(c+3) cycles. While a frequency change is pending, the block does not enter any low-power state.

Top module: `lp_idle_ctrl`

## Requirements
- R1: After reset, `lp_enter`, `lp_exit`, `zq_long`, `stall` and `lp_kind` are all 0, and an access request is granted at once.
- R2: `lp_mode` encodings:
  - 1 selects clock stop.
  - 2 selects self-refresh.
  - 4 selects power-down.
  - 0 and every other value disable low-power entry: no `lp_enter` ever occurs.
- R3: The timeout code is ceil(log2(cycles)) - 3. Requests below 16 cycles give code 0. Entry occurs after exactly 2^(code+3) consecutive idle cycles: 10 gives 8, 16 gives 16, 17 gives 32, and 100 gives 128.
- R4: The code saturates at the field maximum of 7, which is 1024 cycles. The self-refresh code is never below 6, which is 512 cycles.
- R5: The performance timeout `tmo_perf` applies when `freq_cur` >= `freq_thr`. Otherwise the power timeout `tmo_pwr` applies.
- R6: Any access request restarts the idle count. While the block is active, the request is granted in the same cycle.
- R7: While the SDRAM is in a low-power state, `stall` is high and requests are not granted. The clock edge that samples a request produces a one-cycle `lp_exit`. `lp_enter` and `lp_exit` never coincide.
- R8: An exit from self-refresh or power-down asserts `zq_long` together with `lp_exit`. `stall` then stays high for exactly `zq_cycles` clock edges, with 0 treated as 1. An exit from clock stop issues no ZQ command, and the access is granted right away.
- R9: While `freq_chg_req` is high, no entry occurs and the idle count is held at zero. Once the request is released, entry needs a full timeout.
- R10: `lp_kind` holds the mode in force when the last entry happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_mode | input | 3 | Low-power state select (0 off, 1 clock stop, 2 self-refresh, 4 power-down) |
| tmo_perf | input | RW | Requested idle cycles at high frequency |
| tmo_pwr | input | RW | Requested idle cycles at low frequency |
| freq_cur | input | FW | Current clock frequency code |
| freq_thr | input | FW | Frequency threshold |
| freq_chg_req | input | 1 | Frequency change pending |
| zq_cycles | input | ZW | Length of the ZQ long calibration window |
| access_req | input | 1 | Access request strobe |
| access_gnt | output | 1 | Access granted this cycle |
| stall | output | 1 | Access port blocked |
| lp_enter | output | 1 | Enter low-power pulse |
| lp_exit | output | 1 | Exit low-power pulse |
| lp_kind | output | 3 | Mode of the last entry |
| zq_long | output | 1 | ZQ long calibration command pulse |

## Verification
A table of configurations sweeps requested timeouts below 16, exactly a power of two, just above a power of two, and large enough to saturate. These are tried with each low-power mode and with frequencies below, equal to and above the threshold. The cases tell the rounding rule apart from truncation, the self-refresh floor apart from the common code, and which of the two timeout inputs is in force. Each entry is followed by an exit, so the ZQ stall window is measured per mode, and clock stop is confirmed to skip calibration. Directed cases cover three things: a second access in the middle of the idle count, a frequency change held across the timeout, and mode codes that must never produce an entry.

// File: rtl/lp_idle_pkg.sv
package lp_idle_pkg;

    localparam logic [2:0] MODE_OFF      = 3'd0;
    localparam logic [2:0] MODE_CLKSTOP  = 3'd1;
    localparam logic [2:0] MODE_SELFREF  = 3'd2;
    localparam logic [2:0] MODE_PWRDN    = 3'd4;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_LOWPWR = 2'd1,
        ST_ZQCAL  = 2'd2
    } lp_state_e;

    // Convert a requested cycle count to a log2 code: ceil(log2) - 3,
    // zero below 16 cycles, then bounded by [code_min, code_max].
    function automatic int unsigned tmo_code(int unsigned cyc,
                                             int unsigned code_max,
                                             int unsigned code_min);
        int unsigned msb;
        int unsigned code;
        msb = 0;
        for (int b = 0; b < 32; b++) begin
            if (cyc[b]) msb = b;
        end
        if (cyc < 16) begin
            code = 0;
        end else begin
            if ((cyc & (cyc - 1)) != 0) msb = msb + 1;
            code = msb - 3;
        end
        if (code < code_min) code = code_min;
        if (code > code_max) code = code_max;
        return code;
    endfunction

    function automatic logic mode_is_lp(logic [2:0] m);
        return (m == MODE_CLKSTOP) || (m == MODE_SELFREF) || (m == MODE_PWRDN);
    endfunction

endpackage

// File: rtl/lp_tmo_enc.sv
module lp_tmo_enc #(
    parameter int RW       = 16,
    parameter int CODE_W   = 3,
    parameter int MIN_CODE = 0
) (
    input  logic [RW-1:0]     req_cycles,
    output logic [CODE_W-1:0] code
);
    import lp_idle_pkg::*;

    localparam int unsigned CODE_MAX = (1 << CODE_W) - 1;

    always_comb begin
        code = CODE_W'(tmo_code(32'(req_cycles), CODE_MAX, MIN_CODE));
    end
endmodule

// File: rtl/lp_idle_timer.sv
module lp_idle_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = run && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lp_idle_ctrl.sv
module lp_idle_ctrl #(
    parameter int RW     = 16,
    parameter int FW     = 8,
    parameter int ZW     = 8,
    parameter int CODE_W = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    lp_mode,
    input  logic [RW-1:0] tmo_perf,
    input  logic [RW-1:0] tmo_pwr,
    input  logic [FW-1:0] freq_cur,
    input  logic [FW-1:0] freq_thr,
    input  logic          freq_chg_req,
    input  logic [ZW-1:0] zq_cycles,
    input  logic          access_req,
    output logic          access_gnt,
    output logic          stall,
    output logic          lp_enter,
    output logic          lp_exit,
    output logic [2:0]    lp_kind,
    output logic          zq_long
);
    import lp_idle_pkg::*;

    localparam int FIELD_MAX = (1 << CODE_W) - 1;
    localparam int CNT_W     = FIELD_MAX + 4;
    localparam int NKIND     = 3;
    localparam int KIND_MIN [NKIND] = '{0, 6, 0};

    lp_state_e        state;
    logic [RW-1:0]    req_sel;
    logic [CODE_W-1:0] codes [NKIND];
    logic [CODE_W-1:0] code_sel;
    logic [CNT_W-1:0] limit;
    logic             run;
    logic             expire;
    logic [ZW-1:0]    zq_lim;
    logic [ZW-1:0]    zcnt;

    // Frequency decides which requested timeout is in force.
    assign req_sel = (freq_cur >= freq_thr) ? tmo_perf : tmo_pwr;

    // One encoder per low-power kind: clock stop, self-refresh, power-down.
    for (genvar k = 0; k < NKIND; k++) begin : g_enc
        lp_tmo_enc #(
            .RW       (RW),
            .CODE_W   (CODE_W),
            .MIN_CODE (KIND_MIN[k])
        ) u_enc (
            .req_cycles (req_sel),
            .code       (codes[k])
        );
    end

    always_comb begin
        case (lp_mode)
            MODE_SELFREF: code_sel = codes[1];
            MODE_PWRDN:   code_sel = codes[2];
            default:      code_sel = codes[0];
        endcase
        limit = (CNT_W'(1) << (int'(code_sel) + 3)) - CNT_W'(1);
    end

    assign run = (state == ST_ACTIVE) && !access_req && !freq_chg_req
                 && mode_is_lp(lp_mode);

    lp_idle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .limit  (limit),
        .expire (expire)
    );

    assign zq_lim     = (zq_cycles == '0) ? ZW'(1) : zq_cycles;
    assign stall      = (state != ST_ACTIVE);
    assign access_gnt = access_req && (state == ST_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_ACTIVE;
            lp_enter <= 1'b0;
            lp_exit  <= 1'b0;
            zq_long  <= 1'b0;
            lp_kind  <= MODE_OFF;
            zcnt     <= '0;
        end else begin
            lp_enter <= 1'b0;
            lp_exit  <= 1'b0;
            zq_long  <= 1'b0;
            case (state)
                ST_ACTIVE: begin
                    if (expire) begin
                        state    <= ST_LOWPWR;
                        lp_enter <= 1'b1;
                        lp_kind  <= lp_mode;
                    end
                end
                ST_LOWPWR: begin
                    if (access_req) begin
                        lp_exit <= 1'b1;
                        if (lp_kind == MODE_CLKSTOP) begin
                            state <= ST_ACTIVE;
                        end else begin
                            state   <= ST_ZQCAL;
                            zq_long <= 1'b1;
                            zcnt    <= '0;
                        end
                    end
                end
                ST_ZQCAL: begin
                    if (zcnt >= zq_lim - ZW'(1)) begin
                        state <= ST_ACTIVE;
                    end else begin
                        zcnt <= zcnt + 1'b1;
                    end
                end
                default: state <= ST_ACTIVE;
            endcase
        end
    end
endmodule

// File: rtl/lp_idle_chk.sv
module lp_idle_chk (
    input logic       clk,
    input logic       rst,
    input logic       freq_chg_req,
    input logic       access_req,
    input logic       access_gnt,
    input logic       stall,
    input logic       lp_enter,
    input logic       lp_exit,
    input logic [2:0] lp_kind,
    input logic       zq_long
);
    assert_grant_clear_R6: assert property (@(posedge clk) disable iff (rst)
        access_gnt |-> (access_req && !stall));

    assert_cmd_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lp_enter, lp_exit}));

    assert_enter_stalls_R7: assert property (@(posedge clk) disable iff (rst)
        lp_enter |-> stall);

    assert_zq_on_exit_R8: assert property (@(posedge clk) disable iff (rst)
        zq_long |-> (lp_exit && stall));

    assert_exit_needs_zq_R8: assert property (@(posedge clk) disable iff (rst)
        (lp_exit && lp_kind != 3'd1) |-> zq_long);

    assert_no_entry_fchg_R9: assert property (@(posedge clk) disable iff (rst)
        freq_chg_req |=> !lp_enter);
endmodule

bind lp_idle_ctrl lp_idle_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .freq_chg_req (freq_chg_req),
    .access_req   (access_req),
    .access_gnt   (access_gnt),
    .stall        (stall),
    .lp_enter     (lp_enter),
    .lp_exit      (lp_exit),
    .lp_kind      (lp_kind),
    .zq_long      (zq_long)
);

// File: tb/sim_lp_idle_ctrl.sv
module sim_lp_idle_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ZQC        = 20;
    localparam int NV         = 8;

    // mode, perf, pwr, freq, expected window, expect ZQ
    localparam int V_MODE [NV] = '{1, 1, 4, 4, 2, 2, 1, 4};
    localparam int V_PERF [NV] = '{10, 16, 500, 100, 16, 3000, 3000, 9};
    localparam int V_PWR  [NV] = '{500, 500, 17, 9, 16, 16, 8, 3000};
    localparam int V_FREQ [NV] = '{120, 100, 99, 150, 150, 200, 200, 10};
    localparam int V_THR  [NV] = '{8, 16, 32, 128, 512, 1024, 1024, 1024};
    localparam int V_ZQ   [NV] = '{0, 0, 1, 1, 1, 1, 0, 1};

    logic        clk = 0;
    logic        rst = 1;
    logic [2:0]  lp_mode = 0;
    logic [15:0] tmo_perf = 0;
    logic [15:0] tmo_pwr = 0;
    logic [7:0]  freq_cur = 0;
    logic [7:0]  freq_thr = 8'd100;
    logic        freq_chg_req = 0;
    logic [7:0]  zq_cycles = 8'(ZQC);
    logic        access_req = 0;
    logic        access_gnt, stall, lp_enter, lp_exit, zq_long;
    logic [2:0]  lp_kind;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_idle_ctrl u0 (
        .clk(clk), .rst(rst), .lp_mode(lp_mode), .tmo_perf(tmo_perf),
        .tmo_pwr(tmo_pwr), .freq_cur(freq_cur), .freq_thr(freq_thr),
        .freq_chg_req(freq_chg_req), .zq_cycles(zq_cycles),
        .access_req(access_req), .access_gnt(access_gnt), .stall(stall),
        .lp_enter(lp_enter), .lp_exit(lp_exit), .lp_kind(lp_kind),
        .zq_long(zq_long)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Pulse one access, then count idle edges until lp_enter appears.
    task automatic count_entry(input int limit, output int n);
        @(negedge clk); access_req = 1;
        @(negedge clk); access_req = 0;
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!lp_enter && n < limit);
        if (!lp_enter) n = -1;
    endtask

    // Request an access while in low power; check exit, ZQ and stall time.
    task automatic do_exit(input int exp_zq, input string tag);
        int m;
        repeat (3) @(negedge clk);
        access_req = 1; #1;
        check(access_gnt == 0 && stall == 1, {tag, " R7 no grant in low power"}, access_gnt, 0);
        @(posedge clk); #1;
        check(lp_exit == 1, {tag, " R7 exit pulse"}, lp_exit, 1);
        check(zq_long == exp_zq, {tag, " R8 zq on exit"}, zq_long, exp_zq);
        m = 0;
        while (!access_gnt && m < 100) begin
            @(posedge clk); #1; m++;
        end
        check(m == (exp_zq ? ZQC : 0), {tag, " R8 stall window"}, m, exp_zq ? ZQC : 0);
        @(negedge clk); access_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        check(!lp_enter && !lp_exit && !zq_long && !stall && lp_kind == 0,
              "R1 reset outputs", {lp_enter, lp_exit, zq_long, stall}, 0);
        access_req = 1; #1;
        check(access_gnt == 1, "R1 grant after reset", access_gnt, 1);
        @(negedge clk); access_req = 0;

        // Table walk: R3 R4 R5 R10 R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            lp_mode  = 3'(V_MODE[i]);
            tmo_perf = 16'(V_PERF[i]);
            tmo_pwr  = 16'(V_PWR[i]);
            freq_cur = 8'(V_FREQ[i]);
            count_entry(V_THR[i] + 5, n);
            check(n == V_THR[i], $sformatf("R3 R4 R5 vec%0d window", i), n, V_THR[i]);
            check(lp_kind == 3'(V_MODE[i]), $sformatf("R10 vec%0d kind", i), lp_kind, V_MODE[i]);
            check(stall == 1, $sformatf("R7 vec%0d stall in lp", i), stall, 1);
            do_exit(V_ZQ[i], $sformatf("vec%0d", i));
        end

        // R6: a second access in mid-count restarts the window
        @(negedge clk);
        lp_mode = 3'd1; tmo_perf = 16'd16; freq_cur = 8'd200;
        access_req = 1;
        @(negedge clk); access_req = 0;
        n = 0;
        repeat (10) begin
            @(posedge clk); #1;
            if (lp_enter) n++;
        end
        check(n == 0, "R6 no early entry", n, 0);
        count_entry(30, n);
        check(n == 16, "R6 restart window", n, 16);
        do_exit(0, "r6");
        access_req = 1; #1;
        check(access_gnt == 1 && stall == 0, "R6 same-cycle grant", access_gnt, 1);
        @(negedge clk); access_req = 0;

        // R9: frequency change blocks entry and clears the count
        lp_mode = 3'd1; tmo_perf = 16'd10;
        freq_chg_req = 1;
        access_req = 1;
        @(negedge clk); access_req = 0;
        n = 0;
        repeat (40) begin
            @(posedge clk); #1;
            if (lp_enter) n++;
        end
        check(n == 0, "R9 no entry during change", n, 0);
        @(negedge clk); freq_chg_req = 0;
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (!lp_enter && n < 20);
        check(n == 8, "R9 full window after change", n, 8);
        do_exit(0, "r9");

        // R2: disabled and unused mode codes never enter
        foreach (V_MODE[k]) begin end
        for (int md = 0; md < 8; md++) begin
            if (md == 1 || md == 2 || md == 4) continue;
            @(negedge clk);
            lp_mode = 3'(md); tmo_perf = 16'd10;
            access_req = 1;
            @(negedge clk); access_req = 0;
            n = 0;
            repeat (30) begin
                @(posedge clk); #1;
                if (lp_enter || stall) n++;
            end
            check(n == 0, $sformatf("R2 mode %0d inert", md), n, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule